// File: doc/BRIEF.md
# Reversible Register-Operand ALU

This execution unit works on a small register file. Every operation it performs can be undone exactly. Each command names an opcode, a destination register A, two source registers B and C, and a direction bit. When the direction bit is set, the unit performs the inverse of the opcode. A program can therefore step backwards through any sequence it ran forwards and recover every earlier register value.

Some operations would normally destroy the old destination value. The unit allows a conditional AND only when its destination is zero, and it undoes that AND only when the destination still equals the product of the sources. A second AND variant folds the product into the destination with an XOR, so it is its own inverse. A command fails when its destination register is also one of its sources, or when it would lose information. A failed command leaves every register untouched and reports an error one cycle after it is accepted. A combinational peek port lets the surrounding logic read any register. After reset, each register holds a fixed seed value, so a program has data to work on without a load path.

Top module: `rev_alu`

## Requirements
- R1: While reset is held, register i holds (i * 0x1357) mod 2^WIDTH, so register 0 holds zero, and cmd_ready is low. cmd_ready is high from the first clock edge after reset is released.
- R2: Opcode 0 sets A to its bitwise complement. Opcode 1 sets A to its two's complement. Both are self-inverse, so the direction bit has no effect on them. A sequence of operations followed by their inverses in reverse order restores every register to its earlier value.
- R3: Opcode 2 adds 1 to A modulo 2^WIDTH going forward and subtracts 1 in reverse, wrapping from 0 to all ones.
- R4: Opcode 3 sets A to A + B forward and to A - B in reverse, both modulo 2^WIDTH.
- R5: Opcode 4 sets A to A XOR B in either direction.
- R6: Opcode 5 rotates A left (forward) or right (reverse) by the value in the low log2(WIDTH) bits of B. The higher bits of B are ignored, and an amount of zero leaves A unchanged.
- R7: Opcode 6 forward writes B AND C into A only when A is zero. Otherwise it reports an error and changes nothing.
- R8: Opcode 6 in reverse clears A to zero only when A equals B AND C. Otherwise it reports an error and changes nothing.
- R9: Opcode 7 sets A to A XOR (B AND C) in either direction and never fails on data.
- R10: A command whose A index equals a source index it uses is rejected with an error and changes nothing. Opcodes 3, 4 and 5 use B; opcodes 6 and 7 use B and C.
- R11: A command is accepted on a clock edge where cmd_valid and cmd_ready are both high. resp_valid is high for exactly the following cycle, and resp_err is high in that cycle when the command was rejected. With cmd_valid low, no register changes and resp_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Opcode |
| cmd_rev | input | 1 | 1 selects the inverse operation |
| cmd_ra | input | log2(NREG) | Destination register index A |
| cmd_rb | input | log2(NREG) | Source register index B |
| cmd_rc | input | log2(NREG) | Source register index C |
| resp_valid | output | 1 | Result of the previous accepted command |
| resp_err | output | 1 | Previous accepted command was rejected |
| peek_idx | input | log2(NREG) | Register index to read |
| peek_data | output | WIDTH | Contents of the register at peek_idx |

## Verification
Each opcode is issued forward and then in reverse on the same registers. Comparing the value after the forward step with the value after the reverse step separates a correct inverse from a wrong direction or a missing carry. The rotate uses an amount whose upper bits are set, which shows whether only the low bits count, and it also uses an amount of zero. The conditional AND is tried with an empty destination, a full destination, a matching and a mismatching undo, and aliased indices, which separates the data-based rejections from the index-based ones. Decrementing zero shows the wrap-around. A final sweep over all registers confirms that the whole program returned them to their seeds.

// File: rtl/rev_alu_pkg.sv
package rev_alu_pkg;
   typedef enum logic [2:0] {
      OP_INV  = 3'd0,
      OP_NEG  = 3'd1,
      OP_INC  = 3'd2,
      OP_ADD  = 3'd3,
      OP_XOR  = 3'd4,
      OP_ROT  = 3'd5,
      OP_CAND = 3'd6,
      OP_XAND = 3'd7
   } op_e;
endpackage

// File: rtl/rev_alu_regfile.sv
module rev_alu_regfile #(
   parameter int          WIDTH = 16,
   parameter int          NREG  = 8,
   parameter int unsigned SEED  = 32'h1357,
   localparam int         AW    = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [AW-1:0]    wa,
   input  logic [WIDTH-1:0] wd,
   input  logic [AW-1:0]    ra,
   input  logic [AW-1:0]    rb,
   input  logic [AW-1:0]    rc,
   input  logic [AW-1:0]    rp,
   output logic [WIDTH-1:0] qa,
   output logic [WIDTH-1:0] qb,
   output logic [WIDTH-1:0] qc,
   output logic [WIDTH-1:0] qp
);
   logic [WIDTH-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREG; i++) begin
         if (rst)
            mem[i] <= WIDTH'(i * SEED);
         else if (we && wa == AW'(i))
            mem[i] <= wd;
      end
   end

   assign qa = mem[ra];
   assign qb = mem[rb];
   assign qc = mem[rc];
   assign qp = mem[rp];
endmodule

// File: rtl/rev_alu_rot.sv
module rev_alu_rot #(
   parameter int  WIDTH = 16,
   localparam int SW    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SW-1:0]    amt,
   input  logic             right,
   output logic [WIDTH-1:0] dout
);
   logic [SW-1:0]    amt_l;
   logic [WIDTH-1:0] st [SW+1];

   // a right rotate by n equals a left rotate by WIDTH - n
   assign amt_l = right ? (SW'(0) - amt) : amt;
   assign st[0] = din;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int SH = 2 ** s;
      assign st[s+1] = amt_l[s] ? {st[s][WIDTH-1-SH:0], st[s][WIDTH-1:WIDTH-SH]}
                                : st[s];
   end

   assign dout = st[SW];
endmodule

// File: rtl/rev_alu_exec.sv
module rev_alu_exec
   import rev_alu_pkg::*;
#(
   parameter int  WIDTH = 16,
   parameter int  NREG  = 8,
   localparam int AW    = $clog2(NREG),
   localparam int SW    = $clog2(WIDTH)
) (
   input  op_e              op,
   input  logic             rev,
   input  logic [AW-1:0]    ia,
   input  logic [AW-1:0]    ib,
   input  logic [AW-1:0]    ic,
   input  logic [WIDTH-1:0] va,
   input  logic [WIDTH-1:0] vb,
   input  logic [WIDTH-1:0] vc,
   output logic [WIDTH-1:0] res,
   output logic             reject
);
   logic [WIDTH-1:0] rot_out;
   logic [WIDTH-1:0] prod;
   logic             alias_b;
   logic             alias_c;

   rev_alu_rot #(.WIDTH(WIDTH)) u_rot (
      .din   (va),
      .amt   (vb[SW-1:0]),
      .right (rev),
      .dout  (rot_out)
   );

   assign prod    = vb & vc;
   assign alias_b = (ia == ib);
   assign alias_c = (ia == ic);

   always_comb begin
      res    = va;
      reject = 1'b0;
      unique case (op)
         OP_INV: res = ~va;
         OP_NEG: res = ~va + WIDTH'(1);
         OP_INC: res = rev ? va - WIDTH'(1) : va + WIDTH'(1);
         OP_ADD: begin
            res    = rev ? va - vb : va + vb;
            reject = alias_b;
         end
         OP_XOR: begin
            res    = va ^ vb;
            reject = alias_b;
         end
         OP_ROT: begin
            res    = rot_out;
            reject = alias_b;
         end
         OP_CAND: begin
            if (rev) begin
               res    = '0;
               reject = alias_b || alias_c || (va != prod);
            end else begin
               res    = prod;
               reject = alias_b || alias_c || (va != '0);
            end
         end
         OP_XAND: begin
            res    = va ^ prod;
            reject = alias_b || alias_c;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rev_alu.sv
module rev_alu
   import rev_alu_pkg::*;
#(
   parameter int          WIDTH = 16,
   parameter int          NREG  = 8,
   parameter int unsigned SEED  = 32'h1357,
   localparam int         AW    = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [2:0]       cmd_op,
   input  logic             cmd_rev,
   input  logic [AW-1:0]    cmd_ra,
   input  logic [AW-1:0]    cmd_rb,
   input  logic [AW-1:0]    cmd_rc,
   output logic             resp_valid,
   output logic             resp_err,
   input  logic [AW-1:0]    peek_idx,
   output logic [WIDTH-1:0] peek_data
);
   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("rev_alu: WIDTH must be a power of two of at least 2");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("rev_alu: NREG must be a power of two of at least 2");
   end

   logic             ready_q;
   logic             accept;
   logic             reject;
   logic             wr_en;
   logic [WIDTH-1:0] wr_data;
   logic [WIDTH-1:0] a_val;
   logic [WIDTH-1:0] b_val;
   logic [WIDTH-1:0] c_val;

   rev_alu_regfile #(.WIDTH(WIDTH), .NREG(NREG), .SEED(SEED)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (wr_en),
      .wa  (cmd_ra),
      .wd  (wr_data),
      .ra  (cmd_ra),
      .rb  (cmd_rb),
      .rc  (cmd_rc),
      .rp  (peek_idx),
      .qa  (a_val),
      .qb  (b_val),
      .qc  (c_val),
      .qp  (peek_data)
   );

   rev_alu_exec #(.WIDTH(WIDTH), .NREG(NREG)) u_exec (
      .op     (op_e'(cmd_op)),
      .rev    (cmd_rev),
      .ia     (cmd_ra),
      .ib     (cmd_rb),
      .ic     (cmd_rc),
      .va     (a_val),
      .vb     (b_val),
      .vc     (c_val),
      .res    (wr_data),
      .reject (reject)
   );

   assign accept    = cmd_valid && ready_q;
   assign wr_en     = accept && !reject;
   assign cmd_ready = ready_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q    <= 1'b0;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
      end else begin
         ready_q    <= 1'b1;
         resp_valid <= accept;
         resp_err   <= accept && reject;
      end
   end
endmodule

// File: rtl/rev_alu_chk.sv
module rev_alu_chk #(
   parameter int  WIDTH = 16,
   parameter int  NREG  = 8,
   localparam int AW    = $clog2(NREG)
) (
   input logic             clk,
   input logic             rst,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [2:0]       cmd_op,
   input logic             cmd_rev,
   input logic [AW-1:0]    cmd_ra,
   input logic [AW-1:0]    cmd_rb,
   input logic [AW-1:0]    cmd_rc,
   input logic             resp_valid,
   input logic             resp_err,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] a_val
);
   logic acc;
   assign acc = cmd_valid && cmd_ready;

   // R11
   resp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> $past(acc));

   // R11
   accept_gives_resp_chk: assert property (@(posedge clk) disable iff (rst)
      acc |=> resp_valid);

   // R11
   err_within_resp_chk: assert property (@(posedge clk) disable iff (rst)
      resp_err |-> resp_valid);

   // R7
   cand_full_dest_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && cmd_op == 3'd6 && !cmd_rev && a_val != '0) |-> !wr_en);

   // R8
   unand_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && cmd_op == 3'd6 && cmd_rev && wr_en) |-> (wr_data == '0));

   // R10
   alias_reject_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && (cmd_op == 3'd3 || cmd_op == 3'd4 || cmd_op == 3'd5 ||
               cmd_op == 3'd6 || cmd_op == 3'd7) && cmd_ra == cmd_rb) |-> !wr_en);

   // R11
   idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |-> !wr_en);
endmodule

bind rev_alu rev_alu_chk #(.WIDTH(WIDTH), .NREG(NREG)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_op     (cmd_op),
   .cmd_rev    (cmd_rev),
   .cmd_ra     (cmd_ra),
   .cmd_rb     (cmd_rb),
   .cmd_rc     (cmd_rc),
   .resp_valid (resp_valid),
   .resp_err   (resp_err),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .a_val      (a_val)
);

// File: tb/rev_alu_tb.sv
`timescale 1ns/1ps
module rev_alu_tb;
   localparam int W  = 16;
   localparam int N  = 8;
   localparam int AW = 3;
   localparam int NV = 25;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_op = '0;
   logic          cmd_rev = 1'b0;
   logic [AW-1:0] cmd_ra = '0;
   logic [AW-1:0] cmd_rb = '0;
   logic [AW-1:0] cmd_rc = '0;
   logic          resp_valid;
   logic          resp_err;
   logic [AW-1:0] peek_idx = '0;
   logic [W-1:0]  peek_data;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rev_alu u_dut (
      .clk        (clk),
      .rst        (rst),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_op     (cmd_op),
      .cmd_rev    (cmd_rev),
      .cmd_ra     (cmd_ra),
      .cmd_rb     (cmd_rb),
      .cmd_rc     (cmd_rc),
      .resp_valid (resp_valid),
      .resp_err   (resp_err),
      .peek_idx   (peek_idx),
      .peek_data  (peek_data)
   );

   // row: {req[3:0], op[2:0], rev, a[2:0], b[2:0], c[2:0], err, expected A after}
   localparam logic [33:0] VEC [NV] = '{
      {4'd2,  3'd0, 1'b0, 3'd1, 3'd0, 3'd0, 1'b0, 16'hECA8}, // R2 complement
      {4'd2,  3'd0, 1'b1, 3'd1, 3'd0, 3'd0, 1'b0, 16'h1357}, // R2 complement again
      {4'd2,  3'd1, 1'b0, 3'd2, 3'd0, 3'd0, 1'b0, 16'hD952}, // R2 negate
      {4'd2,  3'd1, 1'b0, 3'd2, 3'd0, 3'd0, 1'b0, 16'h26AE}, // R2 negate again
      {4'd3,  3'd2, 1'b0, 3'd3, 3'd0, 3'd0, 1'b0, 16'h3A06}, // R3 increment
      {4'd3,  3'd2, 1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 16'h3A05}, // R3 decrement
      {4'd4,  3'd3, 1'b0, 3'd4, 3'd5, 3'd0, 1'b0, 16'hAE0F}, // R4 add
      {4'd4,  3'd3, 1'b1, 3'd4, 3'd5, 3'd0, 1'b0, 16'h4D5C}, // R4 subtract
      {4'd5,  3'd4, 1'b0, 3'd6, 3'd7, 3'd0, 1'b0, 16'hF36B}, // R5 xor
      {4'd5,  3'd4, 1'b1, 3'd6, 3'd7, 3'd0, 1'b0, 16'h740A}, // R5 xor undo
      {4'd6,  3'd5, 1'b0, 3'd1, 3'd3, 3'd0, 1'b0, 16'h6AE2}, // R6 rotl by 5 (B=3A05)
      {4'd6,  3'd5, 1'b1, 3'd1, 3'd3, 3'd0, 1'b0, 16'h1357}, // R6 rotr by 5
      {4'd7,  3'd6, 1'b0, 3'd0, 3'd1, 3'd2, 1'b0, 16'h0206}, // R7 empty dest
      {4'd7,  3'd6, 1'b0, 3'd0, 3'd1, 3'd2, 1'b1, 16'h0206}, // R7 full dest
      {4'd8,  3'd6, 1'b1, 3'd0, 3'd1, 3'd3, 1'b1, 16'h0206}, // R8 mismatch
      {4'd8,  3'd6, 1'b1, 3'd0, 3'd1, 3'd2, 1'b0, 16'h0000}, // R8 match clears
      {4'd9,  3'd7, 1'b0, 3'd5, 3'd6, 3'd7, 1'b0, 16'h64B3}, // R9 and-xor
      {4'd9,  3'd7, 1'b1, 3'd5, 3'd6, 3'd7, 1'b0, 16'h60B3}, // R9 and-xor undo
      {4'd10, 3'd3, 1'b0, 3'd4, 3'd4, 3'd0, 1'b1, 16'h4D5C}, // R10 add A=B
      {4'd10, 3'd7, 1'b0, 3'd5, 3'd5, 3'd6, 1'b1, 16'h60B3}, // R10 and-xor A=B
      {4'd10, 3'd6, 1'b0, 3'd0, 3'd1, 3'd0, 1'b1, 16'h0000}, // R10 cond and A=C
      {4'd10, 3'd5, 1'b0, 3'd2, 3'd2, 3'd0, 1'b1, 16'h26AE}, // R10 rotate A=B
      {4'd6,  3'd5, 1'b0, 3'd7, 3'd0, 3'd0, 1'b0, 16'h8761}, // R6 amount zero
      {4'd3,  3'd2, 1'b1, 3'd0, 3'd0, 3'd0, 1'b0, 16'hFFFF}, // R3 wrap below zero
      {4'd3,  3'd2, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 16'h0000}  // R3 wrap to zero
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] seed(input int i);
      return W'(i * 32'h1357);
   endfunction

   task automatic sweep_seeds(input string tag);
      for (int i = 0; i < N; i++) begin
         peek_idx = AW'(i);
         #1;
         chk($sformatf("%s reg%0d", tag, i), 32'(peek_data), 32'(seed(i)));
      end
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values and ready low during reset
      chk("R1 ready in reset", 32'(cmd_ready), 32'd0);
      sweep_seeds("R1 seed");
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R1 ready after reset", 32'(cmd_ready), 32'd1);
      chk("R11 no resp at start", 32'(resp_valid), 32'd0);

      for (int v = 0; v < NV; v++) begin
         cmd_op    = VEC[v][29:27];
         cmd_rev   = VEC[v][26];
         cmd_ra    = VEC[v][25:23];
         cmd_rb    = VEC[v][22:20];
         cmd_rc    = VEC[v][19:17];
         cmd_valid = 1'b1;
         @(posedge clk);
         @(negedge clk);
         chk($sformatf("R11 resp_valid row%0d", v), 32'(resp_valid), 32'd1);
         chk($sformatf("R%0d err row%0d", VEC[v][33:30], v), 32'(resp_err), 32'(VEC[v][16]));
         cmd_valid = 1'b0;
         peek_idx  = VEC[v][25:23];
         #1;
         chk($sformatf("R%0d value row%0d", VEC[v][33:30], v), 32'(peek_data), 32'(VEC[v][15:0]));
      end

      // R11: a command with cmd_valid low is ignored
      cmd_op  = 3'd0;
      cmd_rev = 1'b0;
      cmd_ra  = 3'd7;
      @(posedge clk);
      @(negedge clk);
      chk("R11 idle resp_valid", 32'(resp_valid), 32'd0);
      peek_idx = 3'd7;
      #1;
      chk("R11 idle reg unchanged", 32'(peek_data), 32'h8761);

      // R2: the whole program was undone, every register back at its seed
      sweep_seeds("R2 restored");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule